// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address by descending a radix-tree page table that lives in memory. A translation request carries the virtual address and the base of the root table. The walker then reads one 64-bit entry per tree level through a single-outstanding read port. Each entry it fetches is checked for presence, and the walk ends with a physical frame joined to the page offset, or with a page-fault report that names the level where the walk stopped. The result pulse is meant to fill the translation cache that sits beside the walker.

The walker is started in the same cycle as the translation-cache lookup. When that lookup hits, the cache raises `tlb_hit` and the walk in flight is cancelled. If a read is outstanding at that moment, the walker first absorbs its response and throws it away. The tree depth is an elaboration parameter, 3 or 4. A table is one 4 KiB page of 512 eight-byte entries, so each level consumes 9 address bits above a 12-bit page offset.

Top module: `ptw_walker`

## Requirements
- R1: After reset, and with no request pending, `req_ready` is 1 and `res_valid` and `mem_rd_valid` are 0.
- R2: The first read goes to the root table. The root table's frame is `req_root[PA_W-1:12]`, and bits 11:0 of `req_root` are ignored. Levels are read from LEVELS-1 down to 0. The entry address at level k is the table base plus 8 times the index field `vaddr[12+9k +: 9]`. The address stays stable while a read waits for `mem_rd_ready`.
- R3: An entry is present when bit 0 is 1. The next table's frame number is taken from bits `PA_W-1:12` of the entry, and every other entry bit is ignored.
- R4: A walk that finds present entries at every level returns `res_paddr = {frame of the level-0 entry, vaddr[11:0]}` with `res_fault = 0` and `res_abort = 0`.
- R5: A not-present entry at any level ends the walk with `res_fault = 1`, `res_abort = 0`, and `res_level` equal to that level. No further read is made.
- R6: `tlb_hit` sampled while a walk is in progress ends the walk with `res_abort = 1` and `res_fault = 0`, and no read is issued from that edge on. `tlb_hit` while idle has no effect.
- R7: An abort taken with a read outstanding waits for that read's response before it returns its result. The response is discarded and has no effect on later walks.
- R8: Only one walk runs at a time. `req_ready` is 0 from the accepting edge up to and including the cycle in which `res_valid` is high. `res_valid` is high for exactly one cycle, and `req_ready` is 1 again in the next cycle.
- R9: When memory accepts each read at once and responds in the following cycle, `res_valid` is high in the cycle that begins 2×N clock edges after the accepting edge, where N is the number of entries read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 12+9·LEVELS | Virtual address to translate |
| req_root | input | PA_W | Root table base (low 12 bits ignored) |
| tlb_hit | input | 1 | Parallel cache lookup hit; cancels a walk in progress |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read this cycle |
| mem_rd_addr | output | PA_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 64 | Entry read from memory |
| res_valid | output | 1 | One-cycle result pulse |
| res_fault | output | 1 | Walk ended on a not-present entry |
| res_abort | output | 1 | Walk was cancelled by a cache hit |
| res_level | output | 2 | Level of the faulting entry |
| res_paddr | output | PA_W | Translated physical address (zero unless a translation) |

## Verification
The read for the root level is issued in the cycle after the accepting edge. With a memory that accepts at once and answers in the next cycle, each level costs two edges. A finished walk therefore reports 2×N edges after acceptance. An abort reports one edge after the sampled hit if no read is in flight, or one edge after the pending response otherwise. The bench drives inputs at falling edges, counts falling edges from acceptance until `res_valid` appears, and compares that count with 2×N in the zero-stall runs. In the stalled and random-latency runs it only requires that the result arrives with no read still unanswered, and that `req_ready` stays low the whole time.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Page geometry: a table is one page of 2**IDX_W entries of 2**PTE_SZ_LOG bytes.
  localparam int PAGE_W     = 12;
  localparam int IDX_W      = 9;
  localparam int PTE_SZ_LOG = 3;
  localparam int PTE_W      = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DRAIN,
    ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    RK_XLATE,
    RK_FAULT,
    RK_ABORT
  } res_kind_e;

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel
  import ptw_pkg::*;
#(
  parameter int LEVELS = 4,
  localparam int IDXS_W = LEVELS * IDX_W
) (
  input  logic [IDXS_W-1:0] va_index_bits,
  input  logic [1:0]        level,
  output logic [IDX_W-1:0]  index
);

  logic [IDX_W-1:0] field [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_field
    assign field[g] = va_index_bits[g*IDX_W +: IDX_W];
  end

  always_comb begin
    index = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (level == 2'(k)) begin
        index = field[k];
      end
    end
  end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int PA_W = 40,
  localparam int FR_W = PA_W - PAGE_W
) (
  input  logic [FR_W-1:0]  table_frame,
  input  logic [IDX_W-1:0] index,
  output logic [PA_W-1:0]  entry_addr
);

  // Tables are page aligned and index*entry_size fills the page offset exactly,
  // so base + index*8 is a plain concatenation.
  assign entry_addr = {table_frame, index, {PTE_SZ_LOG{1'b0}}};

endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
  import ptw_pkg::*;
#(
  parameter int PA_W = 40,
  localparam int FR_W = PA_W - PAGE_W
) (
  input  logic [PTE_W-1:0] pte,
  output logic             present,
  output logic [FR_W-1:0]  frame
);

  assign present = pte[0];
  assign frame   = pte[PA_W-1:PAGE_W];

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int PA_W   = 40,
  localparam int VA_W  = PAGE_W + LEVELS * IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PA_W-1:0]  req_root,
  input  logic             tlb_hit,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             res_valid,
  output logic             res_fault,
  output logic             res_abort,
  output logic [1:0]       res_level,
  output logic [PA_W-1:0]  res_paddr
);

  localparam int FR_W   = PA_W - PAGE_W;
  localparam int IDXS_W = LEVELS * IDX_W;
  localparam logic [1:0] TOP_LVL = 2'(LEVELS - 1);

  walk_st_e         st_q, st_d;
  logic [1:0]       lvl_q, lvl_d;
  logic [FR_W-1:0]  tbl_q, tbl_d;
  logic [VA_W-1:0]  va_q;
  logic             ld_req;

  res_kind_e        kind_q, kind_d;
  logic [1:0]       rlvl_q, rlvl_d;
  logic [PA_W-1:0]  rpa_q, rpa_d;
  logic             ld_res;

  logic [IDX_W-1:0] cur_idx;
  logic             pte_present;
  logic [FR_W-1:0]  pte_frame;
  logic             unused_in_bits;

  assign unused_in_bits = ^{mem_rsp_data, req_root[PAGE_W-1:0]};

  ptw_index_sel #(.LEVELS(LEVELS)) i_idx (
    .va_index_bits (va_q[VA_W-1:PAGE_W]),
    .level         (lvl_q),
    .index         (cur_idx)
  );

  ptw_addr_gen #(.PA_W(PA_W)) i_addr (
    .table_frame (tbl_q),
    .index       (cur_idx),
    .entry_addr  (mem_rd_addr)
  );

  ptw_entry_dec #(.PA_W(PA_W)) i_pte (
    .pte     (mem_rsp_data),
    .present (pte_present),
    .frame   (pte_frame)
  );

  // Next-state process
  always_comb begin
    st_d   = st_q;
    lvl_d  = lvl_q;
    tbl_d  = tbl_q;
    ld_req = 1'b0;
    ld_res = 1'b0;
    kind_d = kind_q;
    rlvl_d = rlvl_q;
    rpa_d  = rpa_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req = 1'b1;
          tbl_d  = req_root[PA_W-1:PAGE_W];
          lvl_d  = TOP_LVL;
          st_d   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (tlb_hit) begin
          ld_res = 1'b1;
          kind_d = RK_ABORT;
          rlvl_d = '0;
          rpa_d  = '0;
          st_d   = ST_DONE;
        end else if (mem_rd_ready) begin
          st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (tlb_hit) begin
            ld_res = 1'b1;
            kind_d = RK_ABORT;
            rlvl_d = '0;
            rpa_d  = '0;
            st_d   = ST_DONE;
          end else if (!pte_present) begin
            ld_res = 1'b1;
            kind_d = RK_FAULT;
            rlvl_d = lvl_q;
            rpa_d  = '0;
            st_d   = ST_DONE;
          end else if (lvl_q == 2'd0) begin
            ld_res = 1'b1;
            kind_d = RK_XLATE;
            rlvl_d = '0;
            rpa_d  = {pte_frame, va_q[PAGE_W-1:0]};
            st_d   = ST_DONE;
          end else begin
            tbl_d = pte_frame;
            lvl_d = 2'(lvl_q - 2'd1);
            st_d  = ST_ISSUE;
          end
        end else if (tlb_hit) begin
          st_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (mem_rsp_valid) begin
          ld_res = 1'b1;
          kind_d = RK_ABORT;
          rlvl_d = '0;
          rpa_d  = '0;
          st_d   = ST_DONE;
        end
      end
      ST_DONE: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lvl_q  <= '0;
      tbl_q  <= '0;
      va_q   <= '0;
      kind_q <= RK_XLATE;
      rlvl_q <= '0;
      rpa_q  <= '0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
      tbl_q <= tbl_d;
      if (ld_req) begin
        va_q <= req_vaddr;
      end
      if (ld_res) begin
        kind_q <= kind_d;
        rlvl_q <= rlvl_d;
        rpa_q  <= rpa_d;
      end
    end
  end

  assign req_ready    = (st_q == ST_IDLE);
  assign mem_rd_valid = (st_q == ST_ISSUE) && !tlb_hit;
  assign res_valid    = (st_q == ST_DONE);
  assign res_fault    = (kind_q == RK_FAULT);
  assign res_abort    = (kind_q == RK_ABORT);
  assign res_level    = rlvl_q;
  assign res_paddr    = rpa_q;

  // R2: a read waiting for acceptance keeps its address unless cancelled
  a_r2_rd_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (tlb_hit || (mem_rd_valid && $stable(mem_rd_addr))));

  // R2: an accepted read is never followed by another before its response
  a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);

  // R5: a result is never both a fault and an abort
  a_r5_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_fault && res_abort));

  // R6: a hit during a walk stops further reads
  a_r6_hit_stops_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_hit && !req_ready && !res_valid) |=> !mem_rd_valid);

  // R8: the result is a one-cycle pulse followed by readiness
  a_r8_res_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (!res_valid && req_ready));

  // R8: no acceptance while a result is presented
  a_r8_busy_at_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

endmodule

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;

  localparam int LV = 4;
  localparam int PA = 40;
  localparam int VA = 12 + 9 * LV;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [VA-1:0] req_vaddr;
  logic [PA-1:0] req_root;
  logic          tlb_hit;
  logic          mem_rd_valid;
  logic          mem_rd_ready;
  logic [PA-1:0] mem_rd_addr;
  logic          mem_rsp_valid;
  logic [63:0]   mem_rsp_data;
  logic          res_valid;
  logic          res_fault;
  logic          res_abort;
  logic [1:0]    res_level;
  logic [PA-1:0] res_paddr;

  ptw_walker #(.LEVELS(LV), .PA_W(PA)) i_ptw_walker (
    .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_root, .tlb_hit,
    .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rsp_valid, .mem_rsp_data,
    .res_valid, .res_fault, .res_abort, .res_level, .res_paddr
  );

  int checks = 0;
  int failures = 0;

  // Memory configuration
  logic [63:0] salt = 64'h0123_4567_89ab_cdef;
  logic [63:0] fault_addr = 64'h1;
  bit cfg_stall = 0;
  bit cfg_lat_rand = 0;
  int cfg_lat_max = 0;
  bit block_rd = 0;

  // Memory model state
  int rd_cnt;
  int rsp_cnt;
  logic [PA-1:0] rd_log [0:1023];
  bit pend;
  int pend_cnt;
  logic [PA-1:0] pend_addr;
  int mlat;

  // Expected model
  logic [PA-1:0] exp_path [0:3];
  int exp_n;
  bit exp_fault;
  logic [1:0] exp_lvl;
  logic [PA-1:0] exp_pa;

  function automatic logic [63:0] mix64(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x >> 29);
    y = y * 64'hBF58_476D_1CE4_E5B9;
    y = y ^ (y >> 32);
    y = y * 64'h94D0_49BB_1331_11EB;
    return y ^ (y >> 31);
  endfunction

  // Table contents: pseudo-random frame and junk bits; present unless faulted.
  function automatic logic [63:0] entry_val(input logic [PA-1:0] a);
    logic [63:0] e;
    e = mix64(64'(a) ^ salt);
    e[0] = (64'(a) != fault_addr);
    return e;
  endfunction

  task automatic compute_expect(input logic [VA-1:0] va, input logic [PA-1:0] root);
    logic [PA-13:0] fr;
    logic [63:0] e;
    int lvl;
    fr = root[PA-1:12];
    exp_fault = 0;
    exp_lvl = '0;
    exp_pa = '0;
    exp_n = 0;
    for (int i = 0; i < LV; i++) begin
      lvl = LV - 1 - i;
      exp_path[i] = {fr, va[12 + 9*lvl +: 9], 3'b000};
      exp_n = i + 1;
      e = entry_val(exp_path[i]);
      if (!e[0]) begin
        exp_fault = 1;
        exp_lvl = 2'(lvl);
        break;
      end
      fr = e[PA-1:12];
    end
    if (!exp_fault) exp_pa = {fr, va[11:0]};
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory model: single outstanding read, configurable stall and latency.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      mem_rd_ready  <= 1'b1;
      pend          <= 1'b0;
      pend_cnt      <= 0;
      pend_addr     <= '0;
      rd_cnt        <= 0;
      rsp_cnt       <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_rsp_valid) rsp_cnt <= rsp_cnt + 1;
      if (pend) begin
        if (pend_cnt == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= entry_val(pend_addr);
          pend          <= 1'b0;
        end else begin
          pend_cnt <= pend_cnt - 1;
        end
      end
      if (mem_rd_valid && mem_rd_ready) begin
        rd_log[rd_cnt % 1024] <= mem_rd_addr;
        rd_cnt <= rd_cnt + 1;
        mlat = cfg_lat_rand ? int'($urandom % 32'(cfg_lat_max + 1)) : cfg_lat_max;
        if (mlat == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= entry_val(mem_rd_addr);
        end else begin
          pend      <= 1'b1;
          pend_cnt  <= mlat - 1;
          pend_addr <= mem_rd_addr;
        end
      end
      mem_rd_ready <= block_rd ? 1'b0 : (cfg_stall ? ($urandom % 2 == 0) : 1'b1);
    end
  end

  task automatic run_walk(input logic [VA-1:0] va, input logic [PA-1:0] root,
                          input int fault_i, input int abort_at, input bit chk_lat);
    int n;
    int start;
    int hit_rd;
    bit hit;
    int busy_bad;
    bit ok;
    fault_addr = 64'h1;
    compute_expect(va, root);
    if (fault_i >= 0) begin
      fault_addr = 64'(exp_path[fault_i]);
      compute_expect(va, root);
    end
    start = rd_cnt;
    hit = 0;
    hit_rd = 0;
    busy_bad = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_root  = root;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!res_valid && n < 2000) begin
      if (req_ready) busy_bad++;
      if (n == abort_at) begin
        tlb_hit = 1'b1;
        hit = 1;
        hit_rd = rd_cnt;
      end
      @(negedge clk);
      tlb_hit = 1'b0;
      n++;
    end
    if (n >= 2000) begin
      chk(0, "R8", "walk never returned a result", 64'(n), 64'(0));
      return;
    end
    chk(busy_bad == 0, "R8", "req_ready high during walk", 64'(busy_bad), 64'(0));
    chk(rd_cnt == rsp_cnt, "R7", "reads unanswered at result", 64'(rd_cnt - rsp_cnt), 64'(0));
    if (hit) begin
      chk(res_abort && !res_fault, "R6", "abort result kind {abort,fault}",
          64'({res_abort, res_fault}), 64'(2'b10));
      chk(rd_cnt == hit_rd, "R6", "reads issued after hit", 64'(rd_cnt), 64'(hit_rd));
    end else begin
      ok = ((rd_cnt - start) == exp_n);
      for (int i = 0; i < exp_n; i++) begin
        if (rd_log[(start + i) % 1024] != exp_path[i]) ok = 0;
      end
      chk(ok, "R2,R3", "entry read sequence (count shown)", 64'(rd_cnt - start), 64'(exp_n));
      if (exp_fault) begin
        chk(res_fault && !res_abort && res_level == exp_lvl, "R5", "fault kind/level",
            64'({res_abort, res_fault, res_level}), 64'({2'b01, exp_lvl}));
      end else begin
        chk(!res_fault && !res_abort && res_paddr == exp_pa, "R4", "translated address",
            64'(res_paddr), 64'(exp_pa));
      end
      if (chk_lat) begin
        chk(n == 2 * exp_n, "R9", "result latency in edges", 64'(n), 64'(2 * exp_n));
      end
    end
    @(negedge clk);
    chk(!res_valid && req_ready, "R8", "pulse end {res_valid,req_ready}",
        64'({res_valid, req_ready}), 64'(2'b01));
  endtask

  function automatic logic [VA-1:0] rnd_va();
    return VA'({$urandom, $urandom});
  endfunction

  function automatic logic [PA-1:0] rnd_root();
    return PA'({$urandom, $urandom});
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_root = '0;
    tlb_hit = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready && !res_valid && !mem_rd_valid, "R1", "reset {ready,res_valid,rd_valid}",
        64'({req_ready, res_valid, mem_rd_valid}), 64'(3'b100));

    // R4/R9: zero-stall full translations, root with junk low bits
    run_walk(48'h7f12_3456_789a, 40'h12_3456_7fff, -1, -1, 1);
    run_walk(rnd_va(), rnd_root(), -1, -1, 1);

    // R5: fault at every level
    for (int k = 0; k < LV; k++) begin
      run_walk(rnd_va(), rnd_root(), k, -1, 1);
    end

    // R6: abort while the first read is held off by memory
    block_rd = 1;
    @(negedge clk);
    run_walk(rnd_va(), rnd_root(), -1, 2, 0);
    block_rd = 0;
    @(negedge clk);

    // R7: abort with a read outstanding and a slow response, then a clean walk
    cfg_lat_max = 6;
    run_walk(rnd_va(), rnd_root(), -1, 1, 0);
    cfg_lat_max = 0;
    run_walk(rnd_va(), rnd_root(), -1, -1, 1);

    // R6: hit while idle has no effect
    @(negedge clk);
    tlb_hit = 1'b1;
    @(negedge clk);
    tlb_hit = 1'b0;
    chk(req_ready && !res_valid, "R6", "idle hit {ready,res_valid}",
        64'({req_ready, res_valid}), 64'(2'b10));
    run_walk(rnd_va(), rnd_root(), -1, -1, 1);

    // Random mix: stalls, latencies, faults, aborts
    cfg_stall = 1;
    cfg_lat_rand = 1;
    cfg_lat_max = 3;
    for (int t = 0; t < 150; t++) begin
      int f;
      int a;
      salt = {$urandom, $urandom};
      f = ($urandom % 4 == 0) ? int'($urandom % LV) : -1;
      a = ($urandom % 5 == 0) ? int'($urandom % 14) : -1;
      run_walk(rnd_va(), rnd_root(), f, a, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule